// File: doc/BRIEF.md
# I2C Master SCL Timing Generator with Clock Synchronisation

This block produces the SCL waveform for an I2C master that shares the bus with other masters. A down-counter loaded from a programmable reload value times each half-period of SCL. Once it reaches zero it stays there until the phase logic loads it again. The low half starts with a load as soon as the master pulls SCL low. The high half starts with a load only after the released SCL line has actually been read back high through a two-flop synchroniser. Another device that holds SCL low therefore stretches the high half instead of shortening it. The reload value is roughly the peripheral clock divided by twice the wanted SCL rate, so 100 kHz, 400 kHz and rates up to 1 MHz can all be set. Reload values of 0 and 1 are not accepted: 2 is used instead and an error flag is raised.

The block never drives either bus line high. It only asserts an output enable that pulls the line low. While SCL is high, the block compares the SDA value it wants to send with the synchronised SDA line. If the master has released SDA but reads it low, arbitration is lost. The block then stops driving both lines, pulses a dedicated bus-collision interrupt and stays in this state until `run_i` is dropped. Byte sequencing, start and stop generation and the slave side are handled elsewhere.

Top module: `i2c_sclgen`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `bcol_irq_o`, `arb_lost_o` and `reload_err_o` are all 0.
- R2: When `run_i` rises, `scl_oe_o` is 1 from the next clock edge and stays 1 for exactly N+1 cycles, where N is the effective reload value sampled at that edge.
- R3: After SCL is released, the high half is timed from when the line is seen high. `scl_oe_o` returns to 1 exactly N+3 clock edges after the first edge at which `scl_i` reads high. With no stretching, the high half lasts N+4 cycles.
- R4: A reload value of 0 or 1 is replaced by 2. `reload_err_o` is set by any load of such a value and cleared by a load of a value of 2 or more.
- R5: While another device holds SCL low after release, the counter stays at zero and no new half-period starts: `scl_oe_o` stays 0 for as long as `scl_i` is low.
- R6: During the high half, if `sda_out_i` is 1 and `sda_i` reads 0, `bcol_irq_o` pulses for exactly one cycle 4 edges after SCL was released. `arb_lost_o` becomes 1 at the same edge and both output enables stay 0 until `run_i` falls.
- R7: While running and arbitration is not lost, `sda_oe_o` equals the inverse of `sda_out_i` (1 pulls SDA low). It is 0 when idle or after arbitration is lost.
- R8: When `run_i` is 0, the block returns to idle on the next edge: `scl_oe_o` is 0 and `arb_lost_o` is cleared.
- R9: While `run_i` stays 1, low and high halves alternate indefinitely. Each half reloads from `reload_i` as sampled at that half's start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Generate SCL while 1; 0 returns to idle |
| reload_i | input | CNT_W | Half-period reload value |
| sda_out_i | input | 1 | Data bit to place on SDA (1 = release) |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| bcol_irq_o | output | 1 | One-cycle bus-collision interrupt pulse |
| arb_lost_o | output | 1 | Arbitration lost, lines released |
| reload_err_o | output | 1 | Last load used an illegal value (0 or 1) |

## Verification
The low half is N+1 cycles long from the edge that follows `run_i` or the previous half. The high half is due N+3 edges after the bus first reads high, because two synchroniser stages and the load edge come before the N count-down edges. The collision pulse is due exactly 4 edges after release. A monitor samples `scl_oe_o` on falling clock edges and measures each run of equal values. It compares each run length with the next entry queued by the driver, and these entries are computed from those formulas. The driver checks the flag, the interrupt and the lines at falling edges, counted from the first sample that shows SCL released.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOW  = 3'd1,
    ST_REL  = 3'd2,
    ST_HIGH = 3'd3,
    ST_LOST = 3'd4
  } phase_e;
endpackage

// File: rtl/i2c_sclgen_sync.sv
module i2c_sclgen_sync #(
  parameter int   W       = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/i2c_sclgen_counter.sv
module i2c_sclgen_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] MinVal = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             bad;

  assign bad = (val_i < MinVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= bad ? MinVal : val_i;
      err_q <= bad;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign err_o  = err_q;

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_hold_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
  p_min_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q >= MinVal);
endmodule

// File: rtl/i2c_sclgen_arb.sv
module i2c_sclgen_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_high_i,
  input  logic scl_s_i,
  input  logic sda_rel_i,
  input  logic sda_s_i,
  output logic lose_o,
  output logic irq_o
);
  logic irq_q;

  // released SDA read low while SCL high: another master wins
  assign lose_o = in_high_i & scl_s_i & sda_rel_i & ~sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= lose_o;
  end

  assign irq_o = irq_q;

  p_irq_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
  import i2c_sclgen_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             sda_out_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             bcol_irq_o,
  output logic             arb_lost_o,
  output logic             reload_err_o
);
  localparam int LineW = 2;

  phase_e           st_q, st_d;
  logic [LineW-1:0] line_s;
  logic             scl_s, sda_s;
  logic             zero, load, lose;

  i2c_sclgen_sync #(.W(LineW), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_sclgen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (reload_i),
    .zero_o(zero),
    .err_o (reload_err_o)
  );

  i2c_sclgen_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_high_i(st_q == ST_HIGH),
    .scl_s_i  (scl_s),
    .sda_rel_i(sda_out_i),
    .sda_s_i  (sda_s),
    .lose_o   (lose),
    .irq_o    (bcol_irq_o)
  );

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    if (!run_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d = ST_LOW;
          load = 1'b1;
        end
        ST_LOW:  if (zero) st_d = ST_REL;
        ST_REL:  if (scl_s) begin  // reload only once the bus is seen high
          st_d = ST_HIGH;
          load = 1'b1;
        end
        ST_HIGH: begin
          if (lose) begin
            st_d = ST_LOST;
          end else if (zero) begin
            st_d = ST_LOW;
            load = 1'b1;
          end
        end
        ST_LOST: st_d = ST_LOST;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign scl_oe_o   = (st_q == ST_LOW);
  assign sda_oe_o   = (st_q != ST_IDLE) && (st_q != ST_LOST) && !sda_out_i;
  assign arb_lost_o = (st_q == ST_LOST);

  p_release_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REL && !scl_s && run_i) |=> st_q == ST_REL);
  p_lost_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_lost_o) |-> bcol_irq_o);
  p_idle_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !scl_oe_o && !arb_lost_o);
  p_sda_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o) |-> !sda_out_i && run_i);
endmodule

// File: tb/i2c_sclgen_tb_top.sv
module i2c_sclgen_tb_top;
  localparam int CNT_W = 12;

  typedef struct {
    bit    is_low;
    int    len;
    string req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [CNT_W-1:0] reload = '0;
  logic             sda_out = 1'b1;
  logic             stretch = 1'b0;
  logic             other_sda = 1'b0;
  logic             scl_oe, sda_oe, bcol_irq, arb_lost, reload_err;
  logic             scl_bus, sda_bus;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t q[$];
  logic prev_oe = 1'b0;
  int   run_len = 0;

  always #5 clk = ~clk;

  assign scl_bus = ~(scl_oe | stretch);
  assign sda_bus = ~(sda_oe | other_sda);

  i2c_sclgen #(.CNT_W(CNT_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .run_i       (run),
    .reload_i    (reload),
    .sda_out_i   (sda_out),
    .scl_i       (scl_bus),
    .sda_i       (sda_bus),
    .scl_oe_o    (scl_oe),
    .sda_oe_o    (sda_oe),
    .bcol_irq_o  (bcol_irq),
    .arb_lost_o  (arb_lost),
    .reload_err_o(reload_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input bit lo, input int len, input string req);
    exp_t e;
    e.is_low = lo;
    e.len    = len;
    e.req    = req;
    q.push_back(e);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (q.size() == 0) return;
      @(negedge clk);
    end
    chk(1'b0, "queue drain", q.size(), 0);
    q.delete();
  endtask

  task automatic wait_release();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!scl_oe) return;
    end
    chk(1'b0, "release timeout", 1, 0);
  endtask

  // monitor: measures each run of scl_oe and compares with queued runs
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe !== prev_oe) begin
        if (q.size() > 0 && q[0].is_low == prev_oe) begin
          exp_t e;
          e = q.pop_front();
          chk(run_len == e.len, e.req, run_len, e.len);
        end
        run_len = 1;
        prev_oe = scl_oe;
      end else begin
        run_len++;
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, bcol_irq, arb_lost, reload_err} == 5'b0, "R1", 
        int'({scl_oe, sda_oe, bcol_irq, arb_lost, reload_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({scl_oe, sda_oe, bcol_irq, arb_lost, reload_err} == 5'b0, "R1",
        int'({scl_oe, sda_oe, bcol_irq, arb_lost, reload_err}), 0);

    // R2 R3 R9: N=3 -> low 4, high 7
    reload = 12'd3;
    push(1, 4, "R2"); push(0, 7, "R3"); push(1, 4, "R9");
    push(0, 7, "R9"); push(1, 4, "R9");
    run = 1'b1;
    @(negedge clk);
    sda_out = 1'b0;
    #1 chk(sda_oe == 1'b1, "R7", sda_oe, 1);
    sda_out = 1'b1;
    #1 chk(sda_oe == 1'b0, "R7", sda_oe, 0);
    drain();
    run = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R8", scl_oe, 0);
    sda_out = 1'b0;
    #1 chk(sda_oe == 1'b0, "R7 idle", sda_oe, 0);
    sda_out = 1'b1;
    repeat (3) @(negedge clk);

    // R9: N=10 -> low 11, high 14
    reload = 12'd10;
    push(1, 11, "R9"); push(0, 14, "R9"); push(1, 11, "R9");
    run = 1'b1;
    drain();
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R3 R5: stretch SCL low, D=20 -> high run 20+4+3
    reload = 12'd4;
    stretch = 1'b1;
    push(1, 5, "R2");
    run = 1'b1;
    wait_release();
    push(0, 27, "R3");
    begin
      int drove = 0;
      for (int i = 0; i < 19; i++) begin
        @(negedge clk);
        if (scl_oe) drove++;
      end
      chk(drove == 0, "R5", drove, 0);
    end
    stretch = 1'b0;
    push(1, 5, "R9");
    drain();
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R4: illegal reload 1 -> treated as 2
    reload = 12'd1;
    push(1, 3, "R4"); push(0, 6, "R4");
    run = 1'b1;
    @(negedge clk);
    chk(reload_err == 1'b1, "R4", reload_err, 1);
    drain();
    run = 1'b0;
    repeat (3) @(negedge clk);
    reload = 12'd5;
    push(1, 6, "R4");
    run = 1'b1;
    @(negedge clk);
    chk(reload_err == 1'b0, "R4", reload_err, 0);
    drain();
    run = 1'b0;
    repeat (3) @(negedge clk);
    reload = 12'd0;
    run = 1'b1;
    @(negedge clk);
    chk(reload_err == 1'b1, "R4", reload_err, 1);
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R6: collision during high half
    reload = 12'd4;
    sda_out = 1'b1;
    other_sda = 1'b1;
    run = 1'b1;
    wait_release();
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k < 4) chk(bcol_irq == 1'b0, "R6 early", bcol_irq, 0);
      if (k == 4) begin
        chk(bcol_irq == 1'b1, "R6 pulse", bcol_irq, 1);
        chk(arb_lost == 1'b1, "R6 lost", arb_lost, 1);
      end
      if (k == 5) chk(bcol_irq == 1'b0, "R6 single", bcol_irq, 0);
    end
    repeat (10) @(negedge clk);
    chk(arb_lost == 1'b1 && scl_oe == 1'b0, "R6 hold", {arb_lost, scl_oe}, 2);
    sda_out = 1'b0;
    #1 chk(sda_oe == 1'b0, "R7 lost", sda_oe, 0);
    run = 1'b0;
    @(negedge clk);
    chk(arb_lost == 1'b0, "R8", arb_lost, 0);
    other_sda = 1'b0;
    sda_out = 1'b1;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule